// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block keeps a small set of binary lock flags that two agents, a left side and a right side, use to claim a shared resource between them. The flags sit apart from any data memory. Each side drives a select, a write strobe, an output enable, a flag address and a data word. A write that sets bit 0 to 0 asks for a flag's token, and a write that sets bit 0 to 1 gives it back. A read returns the flag as this side sees it: 0 means this side holds the token, and 1 means it does not.

Each flag remembers an outstanding request from each side. A side that asks while the other side holds the token is queued. When the holder gives the token back, it passes at once to the queued side, with no second request needed. When the flag is free, the first side to ask gets the token. If both sides ask on the same clock edge, the left side wins.

All pins are plain level strobes, sampled on each rising clock edge. There is no stream traffic, so there is no valid/ready handshake and no back-pressure. An access takes effect on the edge that samples it. A read value is captured on the first edge at which the read is active. It then stays frozen until the side drops its select or its output enable, so a polling agent must pulse one of those two between polls.

Top module: `sem_bank2p`

## Requirements
- R1: The flag index comes from address bits [2:0], and only those bits; bits [11:3] never change which of the eight flags is accessed, and an access to one flag leaves every other flag unchanged.
- R2: A write (sel=1, we=1) with data bit 0 = 0 requests the addressed flag and bit 0 = 1 releases it; data bits [15:1] have no effect.
- R3: A request on a free flag grants it to the requester on that edge; afterwards the requester reads 16'h0000 and the other side reads 16'hFFFF.
- R4: A request from the side not holding the token is held as pending; that side keeps reading 16'hFFFF.
- R5: A release by the holder while the other side is pending moves the token to the other side on the same edge; that side reads 16'h0000 until it releases.
- R6: If both sides request a free flag on the same edge, the left side is granted and the right side's request stays pending.
- R7: A read returns the flag bit copied into all 16 data bits (16'h0000 or 16'hFFFF).
- R8: A read (sel=1, oe=1, we=0) captures on its first active edge; the read value then holds, even if the flag or the address changes, until sel or oe goes low.
- R9: After reset every flag is free, no request is pending, and both read outputs show 16'hFFFF.
- R10: A release from a side that neither holds the flag nor has a request pending leaves the flag's state unchanged.
- R11: The two sides never both hold the same flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore select |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W (12) | Left address; bits [2:0] pick the flag |
| l_wdata | input | DATA_W (16) | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W (16) | Left captured read value |
| r_sel | input | 1 | Right semaphore select |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W (12) | Right address; bits [2:0] pick the flag |
| r_wdata | input | DATA_W (16) | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W (16) | Right captured read value |

## Verification
A corrupted request latch or owner state does not show up at once. It becomes visible at the next read that captures the affected flag: the read output changes after the capture edge. For the queued side, it also becomes visible on the edge after the holder releases. A lost pending request shows as 16'hFFFF where 16'h0000 was expected after a handoff. A stuck owner shows as both sides reading 1 after a grant, or as a grant that never passes on. A broken read hold shows within one cycle as a value that moves while the read stays active.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  // Token holder of one flag
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_e;

endpackage

// File: rtl/sem_flag.sv
// One lock flag: an active-low request latch per side plus the current holder.
module sem_flag
  import sem_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_hit,   // left write to this flag
  input  logic l_bit,   // left write bit: 0 request, 1 release
  input  logic r_hit,
  input  logic r_bit,
  output logic l_owns,
  output logic r_owns
);

  logic    req_l, req_r;     // 0 = request outstanding
  logic    nreq_l, nreq_r;
  holder_e state, nstate;

  always_comb begin
    nreq_l = l_hit ? l_bit : req_l;
    nreq_r = r_hit ? r_bit : req_r;
    nstate = state;
    unique case (state)
      // R3 / R6: a free flag goes to the requester, left first on a tie
      HOLD_NONE: begin
        if (!nreq_l)      nstate = HOLD_LEFT;
        else if (!nreq_r) nstate = HOLD_RIGHT;
      end
      // R5: on release, hand over to a pending other side
      HOLD_LEFT: begin
        if (nreq_l) nstate = nreq_r ? HOLD_NONE : HOLD_RIGHT;
      end
      HOLD_RIGHT: begin
        if (nreq_r) nstate = nreq_l ? HOLD_NONE : HOLD_LEFT;
      end
      default: nstate = HOLD_NONE;
    endcase
  end

  // R9: every latch starts released and the flag starts free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_l <= 1'b1;
      req_r <= 1'b1;
      state <= HOLD_NONE;
    end else begin
      req_l <= nreq_l;
      req_r <= nreq_r;
      state <= nstate;
    end
  end

  assign l_owns = (state == HOLD_LEFT);
  assign r_owns = (state == HOLD_RIGHT);

endmodule

// File: rtl/sem_port.sv
// Access decode and read capture for one side.
module sem_port #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 we,
  input  logic                 oe,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_FLAGS-1:0] owns,     // this side holds flag i
  output logic [NUM_FLAGS-1:0] hit,      // one-hot write strobe
  output logic                 wbit,
  output logic [DATA_W-1:0]    rdata
);

  localparam int IDX_W = $clog2(NUM_FLAGS);

  logic [IDX_W-1:0] idx;
  logic             rd_act, rd_q;
  logic             unused_hi;

  // R1: only the low index bits decode; R2: only data bit 0 is taken
  assign idx       = addr[IDX_W-1:0];
  assign wbit      = wdata[0];
  assign unused_hi = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dec
    assign hit[g] = sel & we & (idx == IDX_W'(g));
  end

  assign rd_act = sel & oe & ~we;

  // R8: capture on the first active edge, hold while active
  // R7: the flag bit fills the whole word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      rdata <= '1;
    end else begin
      rd_q <= rd_act;
      if (rd_act && !rd_q) rdata <= {DATA_W{~owns[idx]}};
    end
  end

endmodule

// File: rtl/sem_bank2p.sv
module sem_bank2p #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  logic [NUM_FLAGS-1:0] own_l, own_r;
  logic [NUM_FLAGS-1:0] hit_l, hit_r;
  logic                 bit_l, bit_r;

  sem_port #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_left (
    .clk(clk), .rst_n(rst_n), .sel(l_sel), .we(l_we), .oe(l_oe),
    .addr(l_addr), .wdata(l_wdata), .owns(own_l),
    .hit(hit_l), .wbit(bit_l), .rdata(l_rdata)
  );

  sem_port #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_right (
    .clk(clk), .rst_n(rst_n), .sel(r_sel), .we(r_we), .oe(r_oe),
    .addr(r_addr), .wdata(r_wdata), .owns(own_r),
    .hit(hit_r), .wbit(bit_r), .rdata(r_rdata)
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .l_hit(hit_l[f]), .l_bit(bit_l),
      .r_hit(hit_r[f]), .r_bit(bit_r),
      .l_owns(own_l[f]), .r_owns(own_r[f])
    );
  end

endmodule

// File: rtl/sem_bank2p_chk.sv
module sem_bank2p_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 l_sel,
  input logic                 l_we,
  input logic                 l_oe,
  input logic [DATA_W-1:0]    l_rdata,
  input logic                 r_sel,
  input logic                 r_we,
  input logic                 r_oe,
  input logic [DATA_W-1:0]    r_rdata,
  input logic [NUM_FLAGS-1:0] own_l,
  input logic [NUM_FLAGS-1:0] own_r
);

  logic l_rd, r_rd, any_wr;
  assign l_rd   = l_sel & l_oe & ~l_we;
  assign r_rd   = r_sel & r_oe & ~r_we;
  assign any_wr = (l_sel & l_we) | (r_sel & r_we);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd ##1 l_rd ##1 l_rd |-> $stable(l_rdata));

  a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd ##1 r_rd ##1 r_rd |-> $stable(r_rdata));

  a_r7_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> ($stable(own_l) && $stable(own_r)));

endmodule

bind sem_bank2p sem_bank2p_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_rdata(l_rdata),
  .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_rdata(r_rdata),
  .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank2p_bench.sv
`timescale 1ns/1ps
module sem_bank2p_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l_sel = 0, l_we = 0, l_oe = 0;
  logic [11:0] l_addr = '0;
  logic [15:0] l_wdata = '0;
  logic [15:0] l_rdata;
  logic        r_sel = 0, r_we = 0, r_oe = 0;
  logic [11:0] r_addr = '0;
  logic [15:0] r_wdata = '0;
  logic [15:0] r_rdata;

  int  n_run = 0, n_fail = 0;
  bit  done  = 0;

  always #2.5 clk = ~clk;

  sem_bank2p u_sem_bank2p (.*);

  typedef struct packed {
    logic        right;   // 0 left, 1 right
    logic        is_rd;   // 1 read check, 0 write
    logic [11:0] addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 12'h000, 16'h0000, 16'hFFFF, 8'd9},  // R9 free at start
    '{1'b1, 1'b1, 12'h007, 16'h0000, 16'hFFFF, 8'd9},  // R9
    '{1'b0, 1'b0, 12'h003, 16'hFFFE, 16'h0000, 8'd2},  // R2 bit0=0 requests
    '{1'b0, 1'b1, 12'h003, 16'h0000, 16'h0000, 8'd3},  // R3 holder reads 0, R7
    '{1'b1, 1'b1, 12'hAB3, 16'h0000, 16'hFFFF, 8'd3},  // R3 other reads 1, R1 high bits
    '{1'b0, 1'b1, 12'h004, 16'h0000, 16'hFFFF, 8'd1},  // R1 neighbour untouched
    '{1'b1, 1'b0, 12'h5F3, 16'h0000, 16'h0000, 8'd4},  // R4 right queues
    '{1'b1, 1'b1, 12'h003, 16'h0000, 16'hFFFF, 8'd4},  // R4
    '{1'b0, 1'b1, 12'h003, 16'h0000, 16'h0000, 8'd4},  // R4 left still holds
    '{1'b0, 1'b0, 12'h003, 16'h0001, 16'h0000, 8'd5},  // R5 left releases
    '{1'b1, 1'b1, 12'h003, 16'h0000, 16'h0000, 8'd5},  // R5 right now holds
    '{1'b0, 1'b1, 12'h003, 16'h0000, 16'hFFFF, 8'd5},  // R5
    '{1'b0, 1'b0, 12'h003, 16'h0000, 16'h0000, 8'd4},  // R4 left queues
    '{1'b0, 1'b0, 12'h003, 16'hFFFF, 16'h0000, 8'd2},  // R2 left withdraws
    '{1'b1, 1'b0, 12'h003, 16'h0001, 16'h0000, 8'd5},  // R5 release, none pending
    '{1'b0, 1'b1, 12'h003, 16'h0000, 16'hFFFF, 8'd5},  // R5 flag free
    '{1'b1, 1'b1, 12'h003, 16'h0000, 16'hFFFF, 8'd5},  // R5
    '{1'b1, 1'b0, 12'h005, 16'h0000, 16'h0000, 8'd3},  // R3 right takes 5
    '{1'b0, 1'b0, 12'h805, 16'h0001, 16'h0000, 8'd10}, // R10 stray release
    '{1'b1, 1'b1, 12'h005, 16'h0000, 16'h0000, 8'd10}, // R10 right still holds
    '{1'b0, 1'b1, 12'h005, 16'h0000, 16'hFFFF, 8'd10}, // R10
    '{1'b1, 1'b0, 12'h005, 16'hFFFF, 16'h0000, 8'd2},  // R2 release
    '{1'b0, 1'b0, 12'h005, 16'h0002, 16'h0000, 8'd2},  // R2 bit1 set, bit0 0 requests
    '{1'b0, 1'b1, 12'h005, 16'h0000, 16'h0000, 8'd2},  // R2 left holds
    '{1'b1, 1'b1, 12'h005, 16'h0000, 16'hFFFF, 8'd11}, // R11 not both
    '{1'b0, 1'b1, 12'h006, 16'h0000, 16'hFFFF, 8'd1}   // R1
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic right, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    if (right) begin r_sel = 1; r_we = 1; r_addr = a; r_wdata = d; end
    else       begin l_sel = 1; l_we = 1; l_addr = a; l_wdata = d; end
    @(negedge clk);
    if (right) begin r_sel = 0; r_we = 0; end
    else       begin l_sel = 0; l_we = 0; end
  endtask

  task automatic do_read(input logic right, input logic [11:0] a, input logic [15:0] exp,
                         input string tag);
    @(negedge clk);
    if (right) begin r_sel = 1; r_oe = 1; r_addr = a; end
    else       begin l_sel = 1; l_oe = 1; l_addr = a; end
    @(negedge clk);
    check(tag, right ? r_rdata : l_rdata, exp);
    if (right) begin r_sel = 0; r_oe = 0; end
    else       begin l_sel = 0; l_oe = 0; end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 left after reset", l_rdata, 16'hFFFF);
    check("R9 right after reset", r_rdata, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (VECS[i].is_rd) do_read(VECS[i].right, VECS[i].addr, VECS[i].exp, tag);
      else               do_write(VECS[i].right, VECS[i].addr, VECS[i].data);
    end

    // R6: both sides request flag 2 on the same edge
    @(negedge clk);
    l_sel = 1; l_we = 1; l_addr = 12'h002; l_wdata = 16'h0000;
    r_sel = 1; r_we = 1; r_addr = 12'h002; r_wdata = 16'h0000;
    @(negedge clk);
    l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
    do_read(1'b0, 12'h002, 16'h0000, "R6 left wins tie");
    do_read(1'b1, 12'h002, 16'hFFFF, "R6 right queued");
    do_write(1'b0, 12'h002, 16'h0001);
    do_read(1'b1, 12'h002, 16'h0000, "R6 right gets token after release");
    do_write(1'b1, 12'h002, 16'h0001);
    do_read(1'b0, 12'h002, 16'hFFFF, "R6 free again");

    // R8: held read does not follow a handoff or an address change
    do_write(1'b0, 12'h001, 16'h0000);
    do_write(1'b1, 12'h001, 16'h0000);
    @(negedge clk);
    r_sel = 1; r_oe = 1; r_addr = 12'h001;
    @(negedge clk);
    check("R8 first capture", r_rdata, 16'hFFFF);
    l_sel = 1; l_we = 1; l_addr = 12'h001; l_wdata = 16'h0001;
    @(negedge clk);
    l_sel = 0; l_we = 0;
    r_addr = 12'h003;
    check("R8 held across handoff", r_rdata, 16'hFFFF);
    @(negedge clk);
    check("R8 held across address change", r_rdata, 16'hFFFF);
    r_oe = 0;
    @(negedge clk);
    r_oe = 1; r_addr = 12'h001;
    @(negedge clk);
    check("R8 refresh after toggle", r_rdata, 16'h0000);
    r_sel = 0; r_oe = 0;
    @(negedge clk);

    // R9: reset mid-run frees everything
    do_read(1'b1, 12'h001, 16'h0000, "R5 right holds flag 1");
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 right read cleared by reset", r_rdata, 16'hFFFF);
    for (int f = 0; f < 8; f++) begin
      do_read(1'b0, 12'(f), 16'hFFFF, "R9 left flag free after reset");
      do_read(1'b1, 12'(f), 16'hFFFF, "R9 right flag free after reset");
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule